// File: doc/BRIEF.md
# Scan Vector Weighted Transition Counter

This block watches the serial bit stream that is being shifted into a scan chain of `CHAIN_LEN` cells and, for each test vector, produces two shift-power estimates. The first is a plain toggle count: every pair of consecutively loaded bits that differ adds one. The second is a weighted count. Each such pair is weighted by the number of further shift cycles for which that transition will ripple through the chain. Transitions formed early in the load travel through more cells, so they cost more switching.

A start-of-vector pulse opens a new vector. A bit-valid strobe qualifies each serial bit. After `CHAIN_LEN` accepted bits, a one-cycle done pulse marks both totals as final. A comparator checks the weighted total against a programmable limit and flags the vector as power-risky when the total exceeds that limit. Test flows use the flag to pick out vectors that need a slower shift clock or a different fill.

Top module: `scan_wtc_top`

## Requirements
- R1: Each accepted bit that differs from the previously accepted bit of the same vector adds exactly 1 to `toggleCount`.
- R2: Let k be the arrival order (1 to `CHAIN_LEN`) of the accepted bit that completes a transition. That transition adds `CHAIN_LEN - (k-1)` to `weightedCount`. For a 4-cell chain, the arrival sequence 0,1,1,0 gives toggle count 2 and weighted count 4.
- R3: The first bit of a vector never counts as a transition. An alternating vector gives the maximum totals, `CHAIN_LEN-1` toggles and `CHAIN_LEN*(CHAIN_LEN-1)/2` weighted, and both are represented without overflow.
- R4: A `startVec` pulse clears both counts, the bit index and `riskyVec` by the next cycle. A bit that is valid in the same cycle as `startVec` is taken as bit 1 of the new vector.
- R5: `vecDone` is high for exactly one cycle. That cycle is the one after the `CHAIN_LEN`-th bit is accepted, and both counts are final in it.
- R6: Cycles with `bitValid` low have no effect. Bits after the `CHAIN_LEN`-th bit are ignored until the next `startVec`.
- R7: When a vector completes, `riskyVec` is set if the final weighted count is strictly greater than `riskLimit`, sampled in the cycle of the last bit. The flag is valid together with `vecDone` and holds until the next `startVec`.
- R8: After reset, both counts are 0 and `vecDone` and `riskyVec` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startVec | input | 1 | Start-of-vector pulse |
| bitValid | input | 1 | Qualifies `serialBit` |
| serialBit | input | 1 | Serial scan-in bit |
| riskLimit | input | W_W | Weighted-count threshold |
| toggleCount | output | TOG_W | Unit-weight transition total |
| weightedCount | output | W_W | Position-weighted transition total |
| vecDone | output | 1 | One-cycle pulse when a vector is complete |
| riskyVec | output | 1 | Weighted total exceeded the limit |

## Verification
If the held previous bit is wrong, a spurious or missing transition appears in `toggleCount` one cycle after the offending bit. A wrong bit index shows up first as a wrong increment in `weightedCount`, also in the next cycle. It then shows as a `vecDone` pulse that comes early, late or never. The bench compares every output against a queue-based model on every cycle, so a fault in either piece of state is reported within one clock of the bit it corrupts.

// File: rtl/scan_wtc_pkg.sv
package scan_wtc_pkg;
  typedef struct packed {
    logic clearAll;
    logic addEdge;
    logic finish;
  } scanStrobes_t;
endpackage

// File: rtl/scan_wtc_ctrl.sv
module scan_wtc_ctrl
  import scan_wtc_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  localparam int IDX_W = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startVec,
  input  logic             bitValid,
  input  logic             serialBit,
  output scanStrobes_t     strobes,
  output logic [IDX_W-1:0] bitIdx,
  output logic             vecDone
);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(CHAIN_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHAIN_LEN - 1);

  logic prevBit;
  logic accept;

  always_comb begin
    accept           = bitValid && !startVec && (bitIdx < FULL);
    strobes.clearAll = startVec;
    strobes.addEdge  = accept && (bitIdx != '0) && (serialBit != prevBit);
    strobes.finish   = accept && (bitIdx == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitIdx  <= '0;
      prevBit <= 1'b0;
      vecDone <= 1'b0;
    end else begin
      vecDone <= strobes.finish;
      if (startVec) begin
        bitIdx  <= bitValid ? IDX_W'(1) : '0;
        prevBit <= serialBit;
      end else if (accept) begin
        bitIdx  <= bitIdx + IDX_W'(1);
        prevBit <= serialBit;
      end
    end
  end
endmodule

// File: rtl/scan_wtc_dp.sv
module scan_wtc_dp
  import scan_wtc_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  localparam int IDX_W = $clog2(CHAIN_LEN + 1),
  localparam int MAX_W = CHAIN_LEN * (CHAIN_LEN - 1) / 2,
  localparam int W_W   = $clog2(((MAX_W > CHAIN_LEN) ? MAX_W : CHAIN_LEN) + 1),
  localparam int TOG_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scanStrobes_t     strobes,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic [W_W-1:0]   riskLimit,
  output logic [TOG_W-1:0] toggleCount,
  output logic [W_W-1:0]   weightedCount,
  output logic             riskyVec
);
  logic [W_W-1:0] edgeWeight;
  logic [W_W-1:0] nextWeighted;

  always_comb begin
    edgeWeight   = W_W'(CHAIN_LEN) - W_W'(bitIdx);
    nextWeighted = weightedCount + (strobes.addEdge ? edgeWeight : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clearAll) begin
      toggleCount   <= '0;
      weightedCount <= '0;
      riskyVec      <= 1'b0;
    end else begin
      if (strobes.addEdge) begin
        toggleCount   <= toggleCount + TOG_W'(1);
        weightedCount <= nextWeighted;
      end
      if (strobes.finish) riskyVec <= (nextWeighted > riskLimit);
    end
  end
endmodule

// File: rtl/scan_wtc_top.sv
module scan_wtc_top
  import scan_wtc_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  localparam int IDX_W = $clog2(CHAIN_LEN + 1),
  localparam int MAX_W = CHAIN_LEN * (CHAIN_LEN - 1) / 2,
  localparam int W_W   = $clog2(((MAX_W > CHAIN_LEN) ? MAX_W : CHAIN_LEN) + 1),
  localparam int TOG_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startVec,
  input  logic             bitValid,
  input  logic             serialBit,
  input  logic [W_W-1:0]   riskLimit,
  output logic [TOG_W-1:0] toggleCount,
  output logic [W_W-1:0]   weightedCount,
  output logic             vecDone,
  output logic             riskyVec
);
  scanStrobes_t     strobes;
  logic [IDX_W-1:0] bitIdx;

  scan_wtc_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startVec(startVec), .bitValid(bitValid),
    .serialBit(serialBit), .strobes(strobes), .bitIdx(bitIdx), .vecDone(vecDone)
  );

  scan_wtc_dp #(.CHAIN_LEN(CHAIN_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .bitIdx(bitIdx),
    .riskLimit(riskLimit), .toggleCount(toggleCount),
    .weightedCount(weightedCount), .riskyVec(riskyVec)
  );
endmodule

// File: rtl/scan_wtc_chk.sv
module scan_wtc_chk #(
  parameter int CHAIN_LEN = 16,
  parameter int TOG_W = 4,
  parameter int W_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startVec,
  input logic             bitValid,
  input logic [TOG_W-1:0] toggleCount,
  input logic [W_W-1:0]   weightedCount,
  input logic             vecDone,
  input logic             riskyVec
);
  localparam int MAX_W = CHAIN_LEN * (CHAIN_LEN - 1) / 2;

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    startVec |=> (toggleCount == '0) && (weightedCount == '0) && !riskyVec);

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vecDone |=> !vecDone);

  assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(weightedCount) >= int'(toggleCount));

  assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(toggleCount) <= CHAIN_LEN - 1) && (int'(weightedCount) <= MAX_W));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bitValid && !startVec) |=> $stable(toggleCount) && $stable(weightedCount));

  assert_risky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(riskyVec) |-> vecDone);
endmodule

bind scan_wtc_top scan_wtc_chk #(.CHAIN_LEN(CHAIN_LEN), .TOG_W(TOG_W), .W_W(W_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .startVec(startVec), .bitValid(bitValid),
  .toggleCount(toggleCount), .weightedCount(weightedCount),
  .vecDone(vecDone), .riskyVec(riskyVec)
);

// File: tb/tb_scan_wtc_top.sv
`timescale 1ns/100ps
module tb_scan_wtc_top;
  localparam int N     = 4;
  localparam int MAX_W = N * (N - 1) / 2;
  localparam int W_W   = $clog2(((MAX_W > N) ? MAX_W : N) + 1);
  localparam int TOG_W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startVec = 1'b0;
  logic bitValid = 1'b0;
  logic serialBit = 1'b0;
  logic [W_W-1:0] riskLimit = '1;
  logic [TOG_W-1:0] toggleCount;
  logic [W_W-1:0] weightedCount;
  logic vecDone, riskyVec;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  scan_wtc_top #(.CHAIN_LEN(N)) dut (
    .clk(clk), .rst_n(rst_n), .startVec(startVec), .bitValid(bitValid),
    .serialBit(serialBit), .riskLimit(riskLimit), .toggleCount(toggleCount),
    .weightedCount(weightedCount), .vecDone(vecDone), .riskyVec(riskyVec)
  );

  // behavioural reference model
  bit q[$];
  int mTog, mW;
  bit mDone, mRisky;

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {}; mTog = 0; mW = 0; mDone = 0; mRisky = 0;
    end else begin
      mDone = 0;
      if (startVec) begin
        q = {}; mTog = 0; mW = 0; mRisky = 0;
        if (bitValid) q.push_back(serialBit);
      end else if (bitValid && q.size() < N) begin
        if (q.size() >= 1 && q[$] != serialBit) begin
          mTog++;
          mW += N - q.size();
        end
        q.push_back(serialBit);
        if (q.size() == N) begin
          mDone = 1;
          mRisky = (mW > int'(riskLimit));
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 toggleCount", int'(toggleCount), mTog);
      check("R2 weightedCount", int'(weightedCount), mW);
      check("R5 vecDone", int'(vecDone), int'(mDone));
      check("R7 riskyVec", int'(riskyVec), int'(mRisky));
    end
  end

  task automatic drive(bit s, bit v, bit b);
    @(negedge clk);
    startVec = s; bitValid = v; serialBit = b;
  endtask

  task automatic idle();
    drive(0, 0, 0);
  endtask

  // sends a full vector, first bit alongside startVec; returns after done is visible
  task automatic sendVec(bit [N-1:0] bits);
    for (int i = 0; i < N; i++) drive(i == 0, 1, bits[N-1-i]);
    idle();
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 toggle after reset", int'(toggleCount), 0);
    check("R8 weighted after reset", int'(weightedCount), 0);
    check("R8 done after reset", int'(vecDone), 0);
    check("R8 risky after reset", int'(riskyVec), 0);
    rst_n = 1'b1;
    idle();

    // R2 hand case 0,1,1,0
    riskLimit = W_W'(10);
    sendVec(4'b0110);
    check("R2 hand-case toggles", int'(toggleCount), 2);
    check("R2 hand-case weighted", int'(weightedCount), 4);
    check("R5 done after last bit", int'(vecDone), 1);
    idle();
    check("R5 done single cycle", int'(vecDone), 0);

    // R3 alternating maximum, R7 strict threshold
    riskLimit = W_W'(5);
    sendVec(4'b0101);
    check("R3 max toggles", int'(toggleCount), N - 1);
    check("R3 max weighted", int'(weightedCount), MAX_W);
    check("R7 risky above limit", int'(riskyVec), 1);
    idle(); idle();
    check("R7 risky held", int'(riskyVec), 1);
    riskLimit = W_W'(6);
    sendVec(4'b1010);
    check("R7 equal limit not risky", int'(riskyVec), 0);

    // R3 first bit never a transition: 1,1,1,1
    sendVec(4'b1111);
    check("R3 constant vector weighted", int'(weightedCount), 0);

    // R6 gaps and surplus bits
    drive(1, 1, 1); idle(); drive(0, 1, 0); idle(); idle();
    drive(0, 1, 0); drive(0, 1, 1); idle();
    check("R6 gapped vector weighted", int'(weightedCount), 3 + 1);
    drive(0, 1, 0); drive(0, 1, 1); idle();
    check("R6 surplus bits ignored", int'(weightedCount), 4);
    check("R6 surplus toggles", int'(toggleCount), 2);

    // R4 restart mid-vector, startVec without a bit
    drive(1, 1, 0); drive(0, 1, 1); drive(0, 1, 0);
    drive(1, 0, 0); idle();
    check("R4 cleared weighted", int'(weightedCount), 0);
    check("R4 cleared toggles", int'(toggleCount), 0);
    drive(0, 1, 1); drive(0, 1, 0); drive(0, 1, 1); drive(0, 1, 0); idle();
    check("R4 fresh vector weighted", int'(weightedCount), MAX_W);

    // random traffic, compared by the model every cycle
    for (int n = 0; n < 400; n++) begin
      riskLimit = W_W'($urandom_range(0, MAX_W));
      drive(($urandom_range(0, 15) == 0), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    for (int n = 0; n < 40; n++) sendVec(N'($urandom));
    idle();
    finish_run();
  end
endmodule